// File: doc/BRIEF.md
# Parallel RGB Output Formatter

This block sits between a display timing generator and the pins of a parallel RGB panel. Each pixel clock it takes one 24-bit pixel (red in bits 23:16, green in 15:8, blue in 7:0) together with horizontal sync, vertical sync and data-enable strobes. It reorders the three colour channels, packs the result onto 24 data lines in one of several layouts with zero padding, and conditions each strobe: polarity inversion, launch on the rising or the falling clock edge, and forcing to its inactive level. It also drives a copy of the pixel clock with selectable polarity.

A single 17-bit control register, reached through a plain synchronous write port and a combinational read port, holds every setting. Its bit 0 is a power gate. A small state machine follows it through three states. GATED is the state after reset: outputs are held idle. GATED moves to WAKE when the gate bit reads 1. WAKE lasts exactly one cycle and keeps the datapath cleared. From WAKE the machine moves to ACTIVE if the gate is still 1, and back to GATED if it is not. ACTIVE registers pixels and strobes, and falls back to GATED as soon as the gate reads 0.

Software locates the block by reading any offset other than zero, which always returns a fixed identification word.

Top module: `rgbfmt_out`

## Requirements
- R1: After reset the control register reads 0, the data lines and all three strobe outputs are 0, and the pixel clock output is held at 0.
- R2: A write to offset 0 stores write-data bits 16:0 in the control register. A read of offset 0 returns those 17 bits, with bits 31:17 reading 0.
- R3: A read of any nonzero offset returns 32'h0064_7069. A write to a nonzero offset leaves the control register unchanged.
- R4: Bit 0 gates the block. Suppose a write sets it at clock edge E. The state machine passes GATED -> WAKE at E+1 and WAKE -> ACTIVE at E+2, and the pixel sampled at E+3 is the first to appear. Outside ACTIVE the data lines are 0.
- R5: Once bit 0 is cleared, the next clock edge makes the outputs idle: data 0, each strobe at its inactive level, and the pixel clock output held.
- R6: Bits 15:14 select the channel order that fills the first, second and third colour fields: 0 = R,G,B; 1 = B,G,R; 2 = G,R,B; 3 = B,R,G.
- R7: Bits 13:11 select the packing, MSB first, with truncated channels keeping their top bits. Code 1 = 8 zeros,5,6,5. Code 2 = 3 zeros,5,2 zeros,6,3 zeros,5. Code 3 = 2 zeros,5,3 zeros,6,2 zeros,5,1 zero. Code 4 = 6 zeros,6,6,6. Code 5 = 2 zeros before each of three 6-bit fields. Code 6 = 8,8,8.
- R8: Format codes 0 and 7 drive all 24 data lines to 0.
- R9: Data and strobes are registered. A pixel present before a rising clock edge appears on the outputs just after that edge, one cycle of latency.
- R10: Bits 9, 8 and 7 invert hsync, vsync and data-enable respectively. The inactive level of each strobe equals its invert bit.
- R11: Bits 3, 2 and 1 force hsync, vsync and data-enable respectively to their inactive level.
- R12: Bits 6, 5 and 4 make hsync, vsync and data-enable respectively launch on the falling clock edge. Such a strobe changes half a cycle after the rising-edge version would.
- R13: When bit 16 is set, the data lines are 0 for every pixel whose incoming data-enable is low.
- R14: Bit 10 inverts the pixel clock output. In ACTIVE that output is the clock XOR bit 10. Outside ACTIVE it is held at the value of bit 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 24 | Incoming pixel, red 23:16, green 15:8, blue 7:0 |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Data enable, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rgb_o | output | 24 | Packed panel data lines |
| hsync_o | output | 1 | Conditioned horizontal sync |
| vsync_o | output | 1 | Conditioned vertical sync |
| de_o | output | 1 | Conditioned data enable |
| pix_clk_o | output | 1 | Panel pixel clock with selectable polarity |

## Verification
The bench builds the block with ADDR_W = 4 and the default identification word. This lets it sweep all fifteen nonzero offsets for the identification read, and show that a write to one of them leaves the control register untouched. A behavioural model steps the GATED, WAKE and ACTIVE sequence from its own cycle count. The model covers every order code, every format code including the reserved one, and each strobe under invert, force-off and falling-edge launch. Each output is compared every clock, sampled while the clock is high. At that point a falling-edge strobe still carries the previous cycle's value, and the pixel clock output shows its active polarity.

// File: rtl/rgbfmt_pkg.sv
`timescale 1ns/1ps
package rgbfmt_pkg;

    localparam int CHAN_W = 8;
    localparam int PIX_W  = 3 * CHAN_W;
    localparam int NSTB   = 3;
    localparam int CTRL_W = 17;
    localparam int REG_W  = 32;

    // strobe lane index, matches the bit order of the per-strobe fields
    localparam int STB_DE = 0;
    localparam int STB_VS = 1;
    localparam int STB_HS = 2;

    typedef enum logic [1:0] {
        ST_GATED  = 2'd0,
        ST_WAKE   = 2'd1,
        ST_ACTIVE = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        ORD_RGB = 2'd0,
        ORD_BGR = 2'd1,
        ORD_GRB = 2'd2,
        ORD_BRG = 2'd3
    } chan_order_e;

    typedef enum logic [2:0] {
        FMT_BLANK      = 3'd0,
        FMT_565_LOW    = 3'd1,
        FMT_565_SPREAD = 3'd2,
        FMT_565_SHIFT  = 3'd3,
        FMT_666_LOW    = 3'd4,
        FMT_666_SPREAD = 3'd5,
        FMT_888        = 3'd6,
        FMT_RSVD       = 3'd7
    } pack_fmt_e;

    // packed MSB first: bit 16 down to bit 0
    typedef struct packed {
        logic              blank;    // 16
        chan_order_e       order;    // 15:14
        pack_fmt_e         fmt;      // 13:11
        logic              clk_inv;  // 10
        logic [NSTB-1:0]   inv;      // 9:7
        logic [NSTB-1:0]   fall;     // 6:4
        logic [NSTB-1:0]   off;      // 3:1
        logic              en;       // 0
    } ctrl_t;

endpackage

// File: rtl/rgbfmt_regs.sv
`timescale 1ns/1ps
module rgbfmt_regs
    import rgbfmt_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl_o
);

    localparam int PAD_W = REG_W - CTRL_W;

    ctrl_t ctrl_q;
    logic  hit_ctrl;
    logic  unused_wdata_hi;

    assign hit_ctrl        = (addr == '0);
    assign unused_wdata_hi = ^wdata[REG_W-1:CTRL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we && hit_ctrl) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        if (hit_ctrl) begin
            rdata = {{PAD_W{1'b0}}, ctrl_q};
        end else begin
            rdata = ID_VALUE;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/rgbfmt_shuffle.sv
`timescale 1ns/1ps
module rgbfmt_shuffle
    import rgbfmt_pkg::*;
(
    input  logic [PIX_W-1:0]  pix_i,
    input  chan_order_e       order_i,
    output logic [CHAN_W-1:0] slot_a_o,
    output logic [CHAN_W-1:0] slot_b_o,
    output logic [CHAN_W-1:0] slot_c_o
);

    logic [CHAN_W-1:0] red, grn, blu;

    assign red = pix_i[PIX_W-1 -: CHAN_W];
    assign grn = pix_i[2*CHAN_W-1 -: CHAN_W];
    assign blu = pix_i[CHAN_W-1:0];

    always_comb begin
        unique case (order_i)
            ORD_RGB: begin
                slot_a_o = red; slot_b_o = grn; slot_c_o = blu;
            end
            ORD_BGR: begin
                slot_a_o = blu; slot_b_o = grn; slot_c_o = red;
            end
            ORD_GRB: begin
                slot_a_o = grn; slot_b_o = red; slot_c_o = blu;
            end
            default: begin
                slot_a_o = blu; slot_b_o = red; slot_c_o = grn;
            end
        endcase
    end

endmodule

// File: rtl/rgbfmt_pack.sv
`timescale 1ns/1ps
module rgbfmt_pack
    import rgbfmt_pkg::*;
(
    input  logic [CHAN_W-1:0] a_i,
    input  logic [CHAN_W-1:0] b_i,
    input  logic [CHAN_W-1:0] c_i,
    input  pack_fmt_e         fmt_i,
    output logic [PIX_W-1:0]  bus_o
);

    localparam int W5 = CHAN_W - 3;
    localparam int W6 = CHAN_W - 2;

    logic [W5-1:0] a5, c5;
    logic [W6-1:0] a6, b6, c6;

    // truncation keeps the most significant bits of each channel
    assign a5 = a_i[CHAN_W-1 -: W5];
    assign c5 = c_i[CHAN_W-1 -: W5];
    assign a6 = a_i[CHAN_W-1 -: W6];
    assign b6 = b_i[CHAN_W-1 -: W6];
    assign c6 = c_i[CHAN_W-1 -: W6];

    always_comb begin
        unique case (fmt_i)
            FMT_565_LOW:    bus_o = {8'b0, a5, b6, c5};
            FMT_565_SPREAD: bus_o = {3'b0, a5, 2'b0, b6, 3'b0, c5};
            FMT_565_SHIFT:  bus_o = {2'b0, a5, 3'b0, b6, 2'b0, c5, 1'b0};
            FMT_666_LOW:    bus_o = {6'b0, a6, b6, c6};
            FMT_666_SPREAD: bus_o = {2'b0, a6, 2'b0, b6, 2'b0, c6};
            FMT_888:        bus_o = {a_i, b_i, c_i};
            default:        bus_o = '0;
        endcase
    end

endmodule

// File: rtl/rgbfmt_strobe.sv
`timescale 1ns/1ps
module rgbfmt_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic raw_i,
    input  logic inv_i,
    input  logic off_i,
    input  logic fall_i,
    output logic level_o
);

    logic next_lvl;
    logic rise_q;
    logic fall_q;

    // inactive level equals the invert setting
    always_comb begin
        if (!load_i || off_i) begin
            next_lvl = inv_i;
        end else begin
            next_lvl = raw_i ^ inv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
        end else begin
            rise_q <= next_lvl;
        end
    end

    // half-cycle retimed copy for falling-edge launch
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= rise_q;
        end
    end

    assign level_o = fall_i ? fall_q : rise_q;

endmodule

// File: rtl/rgbfmt_out.sv
`timescale 1ns/1ps
module rgbfmt_out
    import rgbfmt_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       pix_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              de_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [23:0]       rgb_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pix_clk_o
);

    ctrl_t             ctrl_q;
    pwr_state_e        state_q, state_d;
    logic              load_en;
    logic              clk_run;
    logic [CHAN_W-1:0] slot_a, slot_b, slot_c;
    logic [PIX_W-1:0]  packed_bus;
    logic [PIX_W-1:0]  gated_bus;
    logic [PIX_W-1:0]  rgb_q;
    logic [NSTB-1:0]   raw_stb;
    logic [NSTB-1:0]   out_stb;

    rgbfmt_regs #(
        .ADDR_W   (ADDR_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .ctrl_o (ctrl_q)
    );

    // ---------------- power-gate state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GATED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATED:  if (ctrl_q.en) state_d = ST_WAKE;
            ST_WAKE:   state_d = ctrl_q.en ? ST_ACTIVE : ST_GATED;
            ST_ACTIVE: if (!ctrl_q.en) state_d = ST_GATED;
            default:   state_d = ST_GATED;
        endcase
    end

    always_comb begin
        load_en = 1'b0;
        clk_run = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                load_en = ctrl_q.en;
                clk_run = 1'b1;
            end
            default: begin
                load_en = 1'b0;
                clk_run = 1'b0;
            end
        endcase
    end

    // ---------------- data path ----------------
    rgbfmt_shuffle u_shuffle (
        .pix_i    (pix_i),
        .order_i  (ctrl_q.order),
        .slot_a_o (slot_a),
        .slot_b_o (slot_b),
        .slot_c_o (slot_c)
    );

    rgbfmt_pack u_pack (
        .a_i   (slot_a),
        .b_i   (slot_b),
        .c_i   (slot_c),
        .fmt_i (ctrl_q.fmt),
        .bus_o (packed_bus)
    );

    assign gated_bus = (ctrl_q.blank && !de_i) ? '0 : packed_bus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb_q <= '0;
        end else if (load_en) begin
            rgb_q <= gated_bus;
        end else begin
            rgb_q <= '0;
        end
    end

    assign rgb_o = rgb_q;

    // ---------------- strobe conditioning ----------------
    always_comb begin
        raw_stb         = '0;
        raw_stb[STB_HS] = hsync_i;
        raw_stb[STB_VS] = vsync_i;
        raw_stb[STB_DE] = de_i;
    end

    for (genvar s = 0; s < NSTB; s++) begin : g_stb
        rgbfmt_strobe u_stb (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_en),
            .raw_i   (raw_stb[s]),
            .inv_i   (ctrl_q.inv[s]),
            .off_i   (ctrl_q.off[s]),
            .fall_i  (ctrl_q.fall[s]),
            .level_o (out_stb[s])
        );
    end

    assign hsync_o = out_stb[STB_HS];
    assign vsync_o = out_stb[STB_VS];
    assign de_o    = out_stb[STB_DE];

    // ---------------- pixel clock output ----------------
    assign pix_clk_o = clk_run ? (clk ^ ctrl_q.clk_inv) : ctrl_q.clk_inv;

endmodule

// File: rtl/rgbfmt_out_chk.sv
`timescale 1ns/1ps
module rgbfmt_out_chk
    import rgbfmt_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [23:0]       rgb_o,
    input logic              hsync_o,
    input logic              pix_clk_o,
    input logic [1:0]        state_bits,
    input logic [16:0]       ctrl_bits
);

    assert_id_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != '0) |-> (reg_rdata == ID_VALUE));

    assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == '0) |-> (reg_rdata[31:17] == '0));

    assert_idle_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_bits != ST_ACTIVE) |-> (rgb_o == '0));

    assert_wake_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_bits == ST_WAKE) |=> (state_bits != ST_WAKE));

    assert_hs_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[3] && !ctrl_bits[6] && $stable(ctrl_bits)) |-> (hsync_o == ctrl_bits[9]));

    assert_pclk_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (state_bits != ST_ACTIVE) |-> (pix_clk_o == ctrl_bits[10]));

endmodule

bind rgbfmt_out rgbfmt_out_chk #(
    .ADDR_W   (ADDR_W),
    .ID_VALUE (ID_VALUE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .rgb_o      (rgb_o),
    .hsync_o    (hsync_o),
    .pix_clk_o  (pix_clk_o),
    .state_bits (state_q),
    .ctrl_bits  (ctrl_q)
);

// File: tb/rgbfmt_out_bench.sv
`timescale 1ns/1ps
module rgbfmt_out_bench;

    localparam int          ADDR_W   = 4;
    localparam logic [31:0] ID_VALUE = 32'h0064_7069;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [23:0]       pix_i = '0;
    logic              hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [23:0]       rgb_o;
    logic              hsync_o, vsync_o, de_o, pix_clk_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rgbfmt_out #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_rgbfmt_out (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .hsync_i(hsync_i),
        .vsync_i(vsync_i), .de_i(de_i), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rgb_o(rgb_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_clk_o(pix_clk_o)
    );

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
        end
    endtask

    // reference packing, integer arithmetic from the requirement text
    function automatic int ref_pack(int fmt, int order, int pix, bit blank, bit de);
        int r, g, b, a, m, c;
        r = (pix >> 16) & 255;
        g = (pix >> 8) & 255;
        b = pix & 255;
        case (order)
            0:       begin a = r; m = g; c = b; end
            1:       begin a = b; m = g; c = r; end
            2:       begin a = g; m = r; c = b; end
            default: begin a = b; m = r; c = g; end
        endcase
        if (blank && !de) return 0;
        case (fmt)
            1: return ((a >> 3) << 11) | ((m >> 2) << 5) | (c >> 3);
            2: return ((a >> 3) << 16) | ((m >> 2) << 8) | (c >> 3);
            3: return ((a >> 3) << 17) | ((m >> 2) << 8) | ((c >> 3) << 1);
            4: return ((a >> 2) << 12) | ((m >> 2) << 6) | (c >> 2);
            5: return ((a >> 2) << 16) | ((m >> 2) << 8) | (c >> 2);
            6: return (a << 16) | (m << 8) | c;
            default: return 0;
        endcase
    endfunction

    // ---------------- cycle model, compared every clock ----------------
    int         m_state;   // 0 gated, 1 wake, 2 active
    logic [16:0] m_ctrl;
    logic [23:0] m_data;
    logic [2:0]  m_rise, m_fall;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_ctrl = '0; m_data = '0; m_rise = '0; m_fall = '0;
        end else begin : step
            bit       load;
            logic [2:0] raw;
            logic [2:0] exp_stb;
            load = (m_state == 2) && m_ctrl[0];
            m_data = load ? 24'(ref_pack(int'(m_ctrl[13:11]), int'(m_ctrl[15:14]),
                                         int'(pix_i), m_ctrl[16], de_i)) : 24'h0;
            raw = {hsync_i, vsync_i, de_i};
            m_fall = m_rise;
            for (int k = 0; k < 3; k++) begin
                if (!load || m_ctrl[1 + k]) m_rise[k] = m_ctrl[7 + k];
                else                        m_rise[k] = raw[k] ^ m_ctrl[7 + k];
            end
            case (m_state)
                0:       if (m_ctrl[0]) m_state = 1;
                1:       m_state = m_ctrl[0] ? 2 : 0;
                default: if (!m_ctrl[0]) m_state = 0;
            endcase
            if (reg_we && reg_addr == '0) m_ctrl = reg_wdata[16:0];
            #5;
            if (!done) begin
                for (int k = 0; k < 3; k++)
                    exp_stb[k] = m_ctrl[4 + k] ? m_fall[k] : m_rise[k];
                chk("data", {8'h0, rgb_o}, {8'h0, m_data});
                chk("hsync", {31'h0, hsync_o}, {31'h0, exp_stb[2]});
                chk("vsync", {31'h0, vsync_o}, {31'h0, exp_stb[1]});
                chk("de", {31'h0, de_o}, {31'h0, exp_stb[0]});
                chk("pclk", {31'h0, pix_clk_o},
                    {31'h0, (m_state == 2) ? ~m_ctrl[10] : m_ctrl[10]});
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string what);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(what, reg_rdata, exp);
        reg_addr = '0;
    endtask

    task automatic stream(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_i = 24'($urandom);
            {hsync_i, vsync_i, de_i} = 3'($urandom);
        end
    endtask

    function automatic logic [31:0] cfg(int order, int fmt, int inv, int fall,
                                        int off, bit blank, bit clkinv, bit en);
        return 32'((int'(blank) << 16) | (order << 14) | (fmt << 11) |
                   (int'(clkinv) << 10) | (inv << 7) | (fall << 4) |
                   (off << 1) | int'(en));
    endfunction

    // ---------------- main sequence ----------------
    initial begin
        logic [23:0] held;
        cur_req = "R1";
        cyc(3);
        #5;
        chk("reset data", {8'h0, rgb_o}, 32'h0);
        chk("reset strobes", {29'h0, hsync_o, vsync_o, de_o}, 32'h0);
        chk("reset pclk", {31'h0, pix_clk_o}, 32'h0);
        chk("reset ctrl read", reg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R3";
        for (int a = 1; a < 16; a++) rd(ADDR_W'(a), ID_VALUE, "id read");
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h0, 32'h0, "write to id offset ignored");

        cur_req = "R2";
        wr(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, 32'h0001_FFFE, "ctrl readback");
        stream(4);
        wr(4'h0, 32'h0);
        rd(4'h0, 32'h0, "ctrl cleared");

        cur_req = "R4";
        wr(4'h0, cfg(0, 6, 0, 0, 0, 0, 0, 1));
        stream(10);

        cur_req = "R6";
        for (int o = 0; o < 4; o++) begin
            wr(4'h0, cfg(o, 6, 0, 0, 0, 0, 0, 1));
            stream(6);
        end

        for (int f = 0; f < 8; f++) begin
            cur_req = (f == 0 || f == 7) ? "R8" : "R7";
            wr(4'h0, cfg(f % 4, f, 0, 0, 0, 0, 0, 1));
            stream(6);
        end

        cur_req = "R10";
        wr(4'h0, cfg(0, 6, 7, 0, 0, 0, 0, 1));
        stream(8);
        wr(4'h0, cfg(0, 6, 2, 0, 0, 0, 0, 1));
        stream(8);

        cur_req = "R11";
        wr(4'h0, cfg(0, 6, 5, 0, 7, 0, 0, 1));
        stream(8);
        wr(4'h0, cfg(0, 6, 0, 0, 2, 0, 0, 1));
        stream(8);

        cur_req = "R12";
        wr(4'h0, cfg(0, 6, 0, 7, 0, 0, 0, 1));
        stream(10);
        wr(4'h0, cfg(1, 6, 3, 5, 0, 0, 0, 1));
        stream(10);

        cur_req = "R13";
        wr(4'h0, cfg(0, 6, 0, 0, 0, 1, 0, 1));
        stream(12);
        wr(4'h0, cfg(2, 5, 0, 0, 0, 1, 0, 1));
        stream(12);

        cur_req = "R14";
        wr(4'h0, cfg(0, 6, 0, 0, 0, 0, 1, 1));
        stream(8);

        cur_req = "R5";
        wr(4'h0, cfg(0, 6, 6, 0, 0, 0, 1, 0));
        stream(8);
        wr(4'h0, cfg(0, 6, 0, 0, 0, 0, 0, 0));
        stream(4);

        cur_req = "R9";
        wr(4'h0, cfg(0, 6, 0, 0, 0, 0, 0, 1));
        cyc(4);
        @(negedge clk);
        held = pix_i;
        pix_i = 24'hABCDEF;
        #2;
        chk("before edge holds previous pixel", {8'h0, rgb_o}, {8'h0, held});
        @(posedge clk);
        #5;
        chk("after edge shows new pixel", {8'h0, rgb_o}, 32'h00AB_CDEF);
        stream(6);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL %s watchdog got timeout exp completion", cur_req);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule